// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Decoder

This block sits beside the memory address path and tells the rest of the chip where accesses to the upper-memory window from C0000h to FFFFFh should go. The window is divided into eight 32 KB segments. Each segment has its own enable bit. One shared control register decides, for every enabled segment at once, whether reads are served from internal DRAM (the shadow copy) and whether writes reach that copy or are diverted to the external bus, which makes the copy write-protected.

Software programs the two registers through a small register port and can read them back. For every CPU address placed on `mem_addr`, the block produces combinational read and write routing bits. It also produces two summary flags that cover the BIOS part of the window (E0000h and up). A small two-state machine, with states `RM_QUIET` and `RM_FLAG`, raises `remap_pulse` for one cycle after any write that alters the routing. The transition `RM_QUIET`→`RM_FLAG` is taken on a routing-changing write. `RM_FLAG`→`RM_QUIET` is taken when the next cycle has no such write, and `RM_FLAG`→`RM_FLAG` when it has one.

Top module: `shadow_attr_dec`

## Requirements
- R1: After reset, both registers read 0. Every address routes reads and writes externally (`rd_internal`=0, `wr_internal`=0), both BIOS flags are 0 and `remap_pulse` is 0.
- R2: An address in a segment whose enable bit is 0 gives `rd_internal`=0 and `wr_internal`=0, whatever the control register holds.
- R3: In an enabled segment, `rd_internal` equals control bit 1. When that bit is 1, reads go to internal DRAM.
- R4: In an enabled segment, `wr_internal` is the inverse of control bit 0. When that bit is 1, writes go external and the shadow copy is write-protected.
- R5: `cfg_sel`=0 selects the enable register and `cfg_sel`=1 selects the control register, for both writing and reading. The enable register stores all 8 bits. The control register stores only bits 3:0, and bits 7:4 read as 0.
- R6: `bios_shadow_rd` is 1 exactly when control bit 1 is set and at least one of the enable bits 7:4 (segments at E0000h and above) is set. It does not depend on `mem_addr`.
- R7: `bios_shadow_wr` is 1 exactly when control bit 0 is clear and at least one of the enable bits 7:4 is set. It does not depend on `mem_addr`.
- R8: Addresses below C0000h decode as external read and external write, whatever the register contents.
- R9: A write that changes the enable register, or changes control bits 1:0, makes `remap_pulse` high in the cycle that follows the write's clock edge, and only for that cycle.
- R10: A write that leaves the enable register unchanged, or that changes only control bits 3:2, produces no `remap_pulse`.
- R11: Enable bit i governs only the segment based at C0000h + i·8000h. An address in a neighbouring segment is not affected by bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = segment enable, 1 = shadow control |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| mem_addr | input | 20 | CPU memory address being decoded |
| rd_internal | output | 1 | 1 = read from internal DRAM, 0 = external bus |
| wr_internal | output | 1 | 1 = write to internal DRAM, 0 = external bus |
| bios_shadow_rd | output | 1 | BIOS area shadow read active |
| bios_shadow_wr | output | 1 | BIOS area shadow write active |
| remap_pulse | output | 1 | One-cycle notice that the routing changed |

## Verification
The checker relies on the register contents being visible on `cfg_rdata`. The enable-gating property therefore only constrains cycles in which `cfg_sel` is 0. The stimulus spends most of its decode cycles with `cfg_sel` low, so that property is exercised. The checker also assumes `mem_addr` is a full 20-bit address with no unknown bits, and the bench drives a defined address at every cycle. The pulse properties assume `cfg_we` is a clean strobe. The bench raises it for exactly one cycle per write, from the falling edge.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
    localparam int DATA_W      = 8;
    localparam int CTRL_W      = 4;
    localparam int CTRL_RD_BIT = 1;   // 1: reads served by internal DRAM
    localparam int CTRL_WP_BIT = 0;   // 1: writes go external (protected)

    typedef enum logic {
        RM_QUIET = 1'b0,
        RM_FLAG  = 1'b1
    } remap_state_e;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_attr_pkg::*;
#(
    parameter int SEG_CNT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output logic [SEG_CNT-1:0] seg_en,
    output logic [CTRL_W-1:0]  shd_ctrl,
    output logic               route_change
);
    localparam int PAD_EN   = DATA_W - SEG_CNT;
    localparam int PAD_CTRL = DATA_W - CTRL_W;

    logic en_diff;
    logic ctrl_diff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_en   <= '0;
            shd_ctrl <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) shd_ctrl <= cfg_wdata[CTRL_W-1:0];
            else         seg_en   <= cfg_wdata[SEG_CNT-1:0];
        end
    end

    always_comb begin
        en_diff   = cfg_wdata[SEG_CNT-1:0] != seg_en;
        ctrl_diff = cfg_wdata[1:0] != shd_ctrl[1:0];
        route_change = cfg_we && (cfg_sel ? ctrl_diff : en_diff);
    end

    generate
        if (PAD_EN > 0) begin : g_pad
            always_comb
                cfg_rdata = cfg_sel ? {{PAD_CTRL{1'b0}}, shd_ctrl}
                                    : {{PAD_EN{1'b0}}, seg_en};
        end else begin : g_nopad
            always_comb
                cfg_rdata = cfg_sel ? {{PAD_CTRL{1'b0}}, shd_ctrl} : seg_en;
        end
    endgenerate
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
    import shadow_attr_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          SEG_CNT    = 8,
    parameter int          SEG_SHIFT  = 15,
    parameter int          BIOS_FIRST = 4,
    parameter logic [31:0] WIN_BASE   = 32'h000C_0000
) (
    input  logic [ADDR_W-1:0]  mem_addr,
    input  logic [SEG_CNT-1:0] seg_en,
    input  logic [CTRL_W-1:0]  shd_ctrl,
    output logic               rd_internal,
    output logic               wr_internal,
    output logic               bios_shadow_rd,
    output logic               bios_shadow_wr
);
    localparam int IDX_W  = $clog2(SEG_CNT);
    localparam int WIN_LO = SEG_SHIFT + IDX_W;
    localparam logic [ADDR_W-1:0] BASE_V = WIN_BASE[ADDR_W-1:0];

    logic               in_win;
    logic [IDX_W-1:0]   seg_idx;
    logic [SEG_CNT-1:0] seg_hit;
    logic [SEG_CNT-1:0] bios_mask;

    assign in_win  = mem_addr[ADDR_W-1:WIN_LO] == BASE_V[ADDR_W-1:WIN_LO];
    assign seg_idx = mem_addr[SEG_SHIFT +: IDX_W];

    for (genvar i = 0; i < SEG_CNT; i++) begin : g_seg
        assign seg_hit[i]   = in_win && (seg_idx == IDX_W'(i)) && seg_en[i];
        assign bios_mask[i] = (i >= BIOS_FIRST) && seg_en[i];
    end

    always_comb begin
        rd_internal    = (|seg_hit) &&  shd_ctrl[CTRL_RD_BIT];
        wr_internal    = (|seg_hit) && !shd_ctrl[CTRL_WP_BIT];
        bios_shadow_rd = (|bios_mask) &&  shd_ctrl[CTRL_RD_BIT];
        bios_shadow_wr = (|bios_mask) && !shd_ctrl[CTRL_WP_BIT];
    end
endmodule

// File: rtl/shadow_remap_fsm.sv
module shadow_remap_fsm
    import shadow_attr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic route_change,
    output logic remap_pulse
);
    remap_state_e state_q;
    remap_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RM_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RM_QUIET: if (route_change) state_d = RM_FLAG;
            RM_FLAG:  state_d = route_change ? RM_FLAG : RM_QUIET;
            default:  state_d = RM_QUIET;
        endcase
    end

    always_comb begin
        remap_pulse = 1'b0;
        unique case (state_q)
            RM_QUIET: remap_pulse = 1'b0;
            RM_FLAG:  remap_pulse = 1'b1;
            default:  remap_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/shadow_attr_dec.sv
module shadow_attr_dec
    import shadow_attr_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          SEG_CNT    = 8,
    parameter int          SEG_SHIFT  = 15,
    parameter int          BIOS_FIRST = 4,
    parameter logic [31:0] WIN_BASE   = 32'h000C_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              rd_internal,
    output logic              wr_internal,
    output logic              bios_shadow_rd,
    output logic              bios_shadow_wr,
    output logic              remap_pulse
);
    logic [SEG_CNT-1:0] seg_en;
    logic [CTRL_W-1:0]  shd_ctrl;
    logic               route_change;

    shadow_cfg_regs #(.SEG_CNT(SEG_CNT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .seg_en       (seg_en),
        .shd_ctrl     (shd_ctrl),
        .route_change (route_change)
    );

    shadow_seg_decode #(
        .ADDR_W     (ADDR_W),
        .SEG_CNT    (SEG_CNT),
        .SEG_SHIFT  (SEG_SHIFT),
        .BIOS_FIRST (BIOS_FIRST),
        .WIN_BASE   (WIN_BASE)
    ) u_dec (
        .mem_addr       (mem_addr),
        .seg_en         (seg_en),
        .shd_ctrl       (shd_ctrl),
        .rd_internal    (rd_internal),
        .wr_internal    (wr_internal),
        .bios_shadow_rd (bios_shadow_rd),
        .bios_shadow_wr (bios_shadow_wr)
    );

    shadow_remap_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .route_change (route_change),
        .remap_pulse  (remap_pulse)
    );
endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk
    import shadow_attr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [19:0]       mem_addr,
    input logic              rd_internal,
    input logic              wr_internal,
    input logic              bios_shadow_rd,
    input logic              bios_shadow_wr,
    input logic              remap_pulse
);
    logic below_win;
    logic in_bios;
    assign below_win = mem_addr[19:18] != 2'b11;
    assign in_bios   = mem_addr[19:17] == 3'b111;

    AST_BELOW_WIN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        below_win |-> (!rd_internal && !wr_internal)); // R8

    AST_DISABLED_SEG_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sel && !cfg_rdata[mem_addr[17:15]]) |-> (!rd_internal && !wr_internal)); // R2

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> (cfg_rdata[7:4] == 4'h0)); // R5

    AST_RD_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_internal && in_bios) |-> bios_shadow_rd); // R6

    AST_WR_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_internal && in_bios) |-> bios_shadow_wr); // R7

    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !remap_pulse); // R10

    AST_PULSE_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remap_pulse) |-> $past(cfg_we)); // R9
endmodule

bind shadow_attr_dec shadow_attr_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_sel        (cfg_sel),
    .cfg_rdata      (cfg_rdata),
    .mem_addr       (mem_addr),
    .rd_internal    (rd_internal),
    .wr_internal    (wr_internal),
    .bios_shadow_rd (bios_shadow_rd),
    .bios_shadow_wr (bios_shadow_wr),
    .remap_pulse    (remap_pulse)
);

// File: tb/sim_shadow_attr_dec.sv
`timescale 1ns/1ps
module sim_shadow_attr_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [19:0] mem_addr = '0;
    logic        rd_internal, wr_internal, bios_shadow_rd, bios_shadow_wr, remap_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    shadow_attr_dec u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
        .rd_internal(rd_internal), .wr_internal(wr_internal),
        .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr),
        .remap_pulse(remap_pulse)
    );

    // {enable[7:0], control[3:0], addr[19:0], rd, wr, bios_rd, bios_wr}
    localparam logic [35:0] VEC [12] = '{
        {8'h00, 4'h2, 20'hC0000, 4'b0000},   // R2 disabled
        {8'h01, 4'h2, 20'hC0000, 4'b1100},   // R3 R4 internal both
        {8'h01, 4'h1, 20'hC7FFF, 4'b0000},   // R3 R4 external both
        {8'h01, 4'h2, 20'hC8000, 4'b0000},   // R11 neighbour segment
        {8'h10, 4'h3, 20'hE0000, 4'b1010},   // R6
        {8'h80, 4'h0, 20'hF8000, 4'b0101},   // R7
        {8'h80, 4'h0, 20'hF7FFF, 4'b0001},   // R11 segment 6 off
        {8'hFF, 4'h2, 20'hBFFFF, 4'b0011},   // R8 just below window
        {8'hFF, 4'h2, 20'h00000, 4'b0011},   // R8 low memory
        {8'hFF, 4'h2, 20'hFFFFF, 4'b1111},   // R3 top byte
        {8'h0F, 4'h2, 20'hD8000, 4'b1100},   // R6 R7 flags off below E0000
        {8'h20, 4'h2, 20'hE8000, 4'b1111}    // R11 segment 5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // write one register; returns pulse seen in the cycle after the edge
    task automatic wr_reg(input logic sel, input logic [7:0] data, output logic pulse);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 1'b0;
        pulse = remap_pulse;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        logic p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        mem_addr = 20'hF0000;
        #1;
        check("R1 rd", {31'b0, rd_internal}, 0);
        check("R1 wr", {31'b0, wr_internal}, 0);
        check("R1 flags", {30'b0, bios_shadow_rd, bios_shadow_wr}, 0);
        check("R1 pulse", {31'b0, remap_pulse}, 0);
        cfg_sel = 1'b0; #1; check("R1 enable reg", {24'b0, cfg_rdata}, 0);
        cfg_sel = 1'b1; #1; check("R1 control reg", {24'b0, cfg_rdata}, 0);
        cfg_sel = 1'b0;

        for (int k = 0; k < 12; k++) begin
            wr_reg(1'b0, VEC[k][35:28], p);
            wr_reg(1'b1, {4'h0, VEC[k][27:24]}, p);
            mem_addr = VEC[k][23:4];
            @(negedge clk); #1;
            check($sformatf("R3/R4/R11 vec%0d rd", k), {31'b0, rd_internal}, {31'b0, VEC[k][3]});
            check($sformatf("R4/R2/R8 vec%0d wr", k), {31'b0, wr_internal}, {31'b0, VEC[k][2]});
            check($sformatf("R6 vec%0d bios rd", k), {31'b0, bios_shadow_rd}, {31'b0, VEC[k][1]});
            check($sformatf("R7 vec%0d bios wr", k), {31'b0, bios_shadow_wr}, {31'b0, VEC[k][0]});
        end

        // R5 readback widths
        wr_reg(1'b1, 8'hFF, p);
        cfg_sel = 1'b1; #1; check("R5 control readback", {24'b0, cfg_rdata}, 32'h0F);
        wr_reg(1'b0, 8'hA5, p);
        cfg_sel = 1'b0; #1; check("R5 enable readback", {24'b0, cfg_rdata}, 32'hA5);

        // R9 pulse on enable change, one cycle only
        wr_reg(1'b0, 8'h5A, p);
        check("R9 pulse on enable change", {31'b0, p}, 1);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {31'b0, remap_pulse}, 0);
        // R10 same value
        wr_reg(1'b0, 8'h5A, p);
        check("R10 no pulse same enable", {31'b0, p}, 0);
        // R10 only control bits 3:2
        wr_reg(1'b1, 8'h03, p);
        wr_reg(1'b1, 8'h0F, p);
        check("R10 no pulse ctrl bits 3:2", {31'b0, p}, 0);
        // R9 control bit 0 change
        wr_reg(1'b1, 8'h0E, p);
        check("R9 pulse on ctrl bit0", {31'b0, p}, 1);
        // R9 control bit 1 change
        wr_reg(1'b1, 8'h0C, p);
        check("R9 pulse on ctrl bit1", {31'b0, p}, 1);
        @(negedge clk);
        check("R9 pulse cleared", {31'b0, remap_pulse}, 0);

        // R2 disabled segment with read-internal set
        wr_reg(1'b0, 8'hFE, p);
        wr_reg(1'b1, 8'h02, p);
        mem_addr = 20'hC1234; #1;
        check("R2 disabled seg0 rd", {31'b0, rd_internal}, 0);
        check("R2 disabled seg0 wr", {31'b0, wr_internal}, 0);

        // R1 reset clears back
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; mem_addr = 20'hE0000; #1;
        check("R1 after re-reset rd", {31'b0, rd_internal}, 0);
        check("R1 after re-reset flag", {31'b0, bios_shadow_wr}, 0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule